// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared snooping bus. Each line holds one data word, a tag and one of four coherence states: Invalid, Shared (clean, other copies may exist), Exclusive (clean, sole copy) or Modified (dirty, sole copy). Processor reads, writes and replace requests are served from the line array. When bus traffic is needed, the block issues a one-cycle bus command, waits one cycle, and then completes.

Every controller on the bus watches the other masters' commands on a snoop port. A controller that holds the addressed block drives a wired-OR shared line one cycle after a snooped bus read. The requester samples that line, together with the memory data, in the same cycle and uses it to decide whether the new line is filled as Shared or Exclusive. An Exclusive line can then be written with no bus traffic at all. Snooped reads demote lines to Shared. Snooped read-exclusive and upgrade commands invalidate lines. Dirty lines are flushed in both cases.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is 1, and `bus_valid`, `cpu_done`, `shared_out` and `flush_valid` are 0.
- R2: A read (`cpu_op`=0) whose tag matches a line in Shared, Exclusive or Modified raises `cpu_done` with the stored word in the cycle after acceptance. No bus command is issued.
- R3: A read miss puts `bus_cmd`=1 (bus read) with the request address on the bus in the cycle after acceptance. One cycle later `shared_in` and `mem_rdata` are sampled. The line is installed as Shared if `shared_in` was 1 and as Exclusive otherwise. `cpu_done` rises with the memory word in the cycle after the sample.
- R4: A write (`cpu_op`=1) in Modified or Exclusive updates the word and completes in the cycle after acceptance, with no bus command. In Shared it issues `bus_cmd`=3 (upgrade). On a miss it issues `bus_cmd`=2 (read-exclusive). Both of these complete two cycles after the command. The line always ends Modified, and `cpu_rdata` returns the written word.
- R5: A snooped bus read (`snp_cmd`=1) that hits a valid line drives `shared_out` in the following cycle. The hit demotes Exclusive and Modified to Shared. For a Modified line, `flush_valid` and `flush_data` carry the line's word in that same cycle.
- R6: A snooped read-exclusive (2) or upgrade (3) that hits invalidates the line, and does not drive `shared_out`. A Modified line is flushed in the following cycle.
- R7: A snoop that misses, and any snooped write-back (4), drives neither `shared_out` nor `flush_valid` and changes no line.
- R8: A replace request (`cpu_op`=2 or 3) on a Modified line issues `bus_cmd`=4 with the line's address and word, then invalidates it, completing two cycles after the command. A Shared or Exclusive line is invalidated silently with `cpu_done` in the cycle after acceptance. A miss completes the same way with no change.
- R9: A read or write miss whose index holds a different tag in Modified state first writes that victim back (`bus_cmd`=4, victim address). The fill command follows two cycles later, and `cpu_done` comes two cycles after the fill.
- R10: `cpu_ready` is 0 while a request is in progress or while `snp_valid` is 1. Each bus command lasts exactly one cycle. The address holds the index in its low log2(LINES) bits and the tag above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_op | input | 2 | 0 read, 1 write, 2 or 3 replace |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Request accepted at this edge when valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, or written word for writes |
| bus_valid | output | 1 | Own bus command present |
| bus_cmd | output | 3 | 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Bus command address |
| bus_wdata | output | DATA_W | Write-back word |
| snp_valid | input | 1 | Another master's command is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| shared_in | input | 1 | Wired-OR shared line |
| shared_out | output | 1 | This cache's contribution to the shared line |
| flush_valid | output | 1 | Dirty word being supplied on the bus |
| flush_data | output | DATA_W | Flushed word |
| mem_rdata | input | DATA_W | Memory word, sampled with the shared line |

## Verification
The assertions check several timing rules on every cycle. A shared or flush response only ever follows a snooped command of the right kind. Own bus commands are single-cycle and never overlap an accepted request. Every read, read-exclusive or upgrade is followed by completion exactly two cycles later, and every write-back is followed two cycles later by completion or the next fill. Which state a line lands in, and whether an Exclusive write really stays off the bus, cannot be seen from the ports on any single cycle. The bench shows these through its scenarios, which drive every state against every processor and snoop event and compare against a line model. It also covers victim write-back ordering and the choice of fill state.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2,
      LS_MOD = 2'd3
   } line_st_t;

   typedef enum logic [2:0] {
      BC_NONE = 3'd0,
      BC_RD   = 3'd1,
      BC_RDX  = 3'd2,
      BC_UPG  = 3'd3,
      BC_WB   = 3'd4
   } bus_cmd_t;

   typedef enum logic [1:0] {
      F_IDLE   = 2'd0,
      F_ISSUE  = 2'd1,
      F_SAMPLE = 2'd2
   } req_fsm_t;

   localparam logic [1:0] OP_READ  = 2'd0;
   localparam logic [1:0] OP_WRITE = 2'd1;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(LINES)-1:0] a_ridx,
   output line_st_t                 a_rst,
   output logic [TAG_W-1:0]         a_rtag,
   output logic [DATA_W-1:0]        a_rdata,
   input  logic [$clog2(LINES)-1:0] b_ridx,
   output line_st_t                 b_rst,
   output logic [TAG_W-1:0]         b_rtag,
   output logic [DATA_W-1:0]        b_rdata,
   input  logic                     a_we,
   input  logic [$clog2(LINES)-1:0] a_widx,
   input  line_st_t                 a_wst,
   input  logic [TAG_W-1:0]         a_wtag,
   input  logic [DATA_W-1:0]        a_wdata,
   input  logic                     b_we,
   input  logic [$clog2(LINES)-1:0] b_widx,
   input  line_st_t                 b_wst
);
   localparam int IDX_W = $clog2(LINES);

   line_st_t            st_v  [LINES];
   logic [TAG_W-1:0]    tag_v [LINES];
   logic [DATA_W-1:0]   dat_v [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] dat_r;
      logic              sel_a;
      logic              sel_b;

      assign sel_a = a_we && (a_widx == IDX_W'(g));
      assign sel_b = b_we && (b_widx == IDX_W'(g));

      // processor-side port wins over a snoop write to the same line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r  <= LS_INV;
            tag_r <= '0;
            dat_r <= '0;
         end else if (sel_a) begin
            st_r  <= a_wst;
            tag_r <= a_wtag;
            dat_r <= a_wdata;
         end else if (sel_b) begin
            st_r  <= b_wst;
         end
      end

      assign st_v[g]  = st_r;
      assign tag_v[g] = tag_r;
      assign dat_v[g] = dat_r;
   end

   assign a_rst   = st_v[a_ridx];
   assign a_rtag  = tag_v[a_ridx];
   assign a_rdata = dat_v[a_ridx];
   assign b_rst   = st_v[b_ridx];
   assign b_rtag  = tag_v[b_ridx];
   assign b_rdata = dat_v[b_ridx];

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
#(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  line_st_t          ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              upd_en,
   output line_st_t          upd_st,
   output logic              shared_out,
   output logic              flush_valid,
   output logic [DATA_W-1:0] flush_data
);
   logic hit;
   logic dirty;
   logic sh_d;
   logic fl_d;

   assign hit   = snp_valid && (ln_st != LS_INV) && (ln_tag == snp_tag);
   assign dirty = hit && (ln_st == LS_MOD);

   always_comb begin
      upd_en = 1'b0;
      upd_st = ln_st;
      sh_d   = 1'b0;
      fl_d   = 1'b0;
      case (bus_cmd_t'(snp_cmd))
         BC_RD: begin
            sh_d   = hit;
            fl_d   = dirty;
            upd_en = hit && (ln_st != LS_SHR);
            upd_st = LS_SHR;
         end
         BC_RDX, BC_UPG: begin
            fl_d   = dirty;
            upd_en = hit;
            upd_st = LS_INV;
         end
         default: ;
      endcase
   end

   // responses appear in the cycle after the snooped command
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shared_out  <= 1'b0;
         flush_valid <= 1'b0;
         flush_data  <= '0;
      end else begin
         shared_out  <= sh_d;
         flush_valid <= fl_d;
         if (fl_d) flush_data <= ln_data;
      end
   end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cpu_valid,
   input  logic [1:0]               cpu_op,
   input  logic [ADDR_W-1:0]        cpu_addr,
   input  logic [DATA_W-1:0]        cpu_wdata,
   input  logic                     snp_valid,
   input  logic                     shared_in,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic [IDX_W-1:0]         lk_idx,
   input  line_st_t                 lk_st,
   input  logic [ADDR_W-IDX_W-1:0]  lk_tag,
   input  logic [DATA_W-1:0]        lk_data,
   output logic                     cpu_ready,
   output logic                     cpu_done,
   output logic [DATA_W-1:0]        cpu_rdata,
   output logic                     bus_valid,
   output logic [2:0]               bus_cmd,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic [DATA_W-1:0]        bus_wdata,
   output logic                     wr_en,
   output line_st_t                 wr_st,
   output logic [ADDR_W-IDX_W-1:0]  wr_tag,
   output logic [DATA_W-1:0]        wr_data
);
   localparam int TAG_W = ADDR_W - IDX_W;

   req_fsm_t          fsm_q,   nx_fsm;
   bus_cmd_t          cmd_q,   nx_cmd;
   bus_cmd_t          fill_q,  nx_fill;
   logic              pend_q,  nx_pend;
   logic [ADDR_W-1:0] baddr_q, nx_baddr;
   logic [DATA_W-1:0] bwd_q,   nx_bwd;
   logic [ADDR_W-1:0] raddr_q, nx_raddr;
   logic [DATA_W-1:0] rwd_q,   nx_rwd;
   logic              done_d;
   logic [DATA_W-1:0] rdata_q, nx_rdata;

   logic              accept;
   logic [TAG_W-1:0]  c_tag;
   logic [IDX_W-1:0]  c_idx;
   logic              hit;
   logic              vic_dirty;
   logic              miss_go;
   bus_cmd_t          miss_cmd;

   assign cpu_ready = (fsm_q == F_IDLE) && !snp_valid;
   assign accept    = cpu_valid && cpu_ready;
   assign c_tag     = cpu_addr[ADDR_W-1:IDX_W];
   assign c_idx     = cpu_addr[IDX_W-1:0];
   assign lk_idx    = (fsm_q == F_IDLE) ? c_idx : raddr_q[IDX_W-1:0];
   assign hit       = (lk_st != LS_INV) && (lk_tag == c_tag);
   assign vic_dirty = (lk_st == LS_MOD) && (lk_tag != c_tag);

   always_comb begin
      nx_fsm   = fsm_q;
      nx_cmd   = cmd_q;
      nx_fill  = fill_q;
      nx_pend  = pend_q;
      nx_baddr = baddr_q;
      nx_bwd   = bwd_q;
      nx_raddr = raddr_q;
      nx_rwd   = rwd_q;
      nx_rdata = rdata_q;
      done_d   = 1'b0;
      wr_en    = 1'b0;
      wr_st    = lk_st;
      wr_tag   = lk_tag;
      wr_data  = lk_data;
      miss_go  = 1'b0;
      miss_cmd = BC_RD;
      case (fsm_q)
         F_IDLE: begin
            if (accept) begin
               nx_raddr = cpu_addr;
               nx_rwd   = cpu_wdata;
               nx_pend  = 1'b0;
               if (cpu_op == OP_READ) begin
                  if (hit) begin
                     done_d   = 1'b1;
                     nx_rdata = lk_data;
                  end else begin
                     miss_go  = 1'b1;
                     miss_cmd = BC_RD;
                  end
               end else if (cpu_op == OP_WRITE) begin
                  if (hit && lk_st == LS_SHR) begin
                     nx_cmd   = BC_UPG;
                     nx_baddr = cpu_addr;
                     nx_fsm   = F_ISSUE;
                  end else if (hit) begin
                     wr_en    = 1'b1;
                     wr_st    = LS_MOD;
                     wr_data  = cpu_wdata;
                     done_d   = 1'b1;
                     nx_rdata = cpu_wdata;
                  end else begin
                     miss_go  = 1'b1;
                     miss_cmd = BC_RDX;
                  end
               end else begin
                  if (hit && lk_st == LS_MOD) begin
                     nx_cmd   = BC_WB;
                     nx_baddr = cpu_addr;
                     nx_bwd   = lk_data;
                     nx_fsm   = F_ISSUE;
                  end else begin
                     if (hit) begin
                        wr_en = 1'b1;
                        wr_st = LS_INV;
                     end
                     done_d   = 1'b1;
                     nx_rdata = lk_data;
                  end
               end
               if (miss_go) begin
                  nx_fsm = F_ISSUE;
                  if (vic_dirty) begin
                     nx_cmd   = BC_WB;
                     nx_baddr = {lk_tag, c_idx};
                     nx_bwd   = lk_data;
                     nx_pend  = 1'b1;
                     nx_fill  = miss_cmd;
                  end else begin
                     nx_cmd   = miss_cmd;
                     nx_baddr = cpu_addr;
                  end
               end
            end
         end
         F_ISSUE: nx_fsm = F_SAMPLE;
         F_SAMPLE: begin
            nx_fsm = F_IDLE;
            case (cmd_q)
               BC_WB: begin
                  wr_en = 1'b1;
                  wr_st = LS_INV;
                  if (pend_q) begin
                     nx_cmd   = fill_q;
                     nx_baddr = raddr_q;
                     nx_pend  = 1'b0;
                     nx_fsm   = F_ISSUE;
                  end else begin
                     done_d   = 1'b1;
                     nx_rdata = bwd_q;
                  end
               end
               BC_RD: begin
                  wr_en    = 1'b1;
                  wr_st    = shared_in ? LS_SHR : LS_EXC;
                  wr_tag   = raddr_q[ADDR_W-1:IDX_W];
                  wr_data  = mem_rdata;
                  done_d   = 1'b1;
                  nx_rdata = mem_rdata;
               end
               BC_RDX, BC_UPG: begin
                  wr_en    = 1'b1;
                  wr_st    = LS_MOD;
                  wr_tag   = raddr_q[ADDR_W-1:IDX_W];
                  wr_data  = rwd_q;
                  done_d   = 1'b1;
                  nx_rdata = rwd_q;
               end
               default: ;
            endcase
         end
         default: nx_fsm = F_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q    <= F_IDLE;
         cmd_q    <= BC_NONE;
         fill_q   <= BC_NONE;
         pend_q   <= 1'b0;
         baddr_q  <= '0;
         bwd_q    <= '0;
         raddr_q  <= '0;
         rwd_q    <= '0;
         cpu_done <= 1'b0;
         rdata_q  <= '0;
      end else begin
         fsm_q    <= nx_fsm;
         cmd_q    <= nx_cmd;
         fill_q   <= nx_fill;
         pend_q   <= nx_pend;
         baddr_q  <= nx_baddr;
         bwd_q    <= nx_bwd;
         raddr_q  <= nx_raddr;
         rwd_q    <= nx_rwd;
         cpu_done <= done_d;
         rdata_q  <= nx_rdata;
      end
   end

   assign cpu_rdata = rdata_q;
   assign bus_valid = (fsm_q == F_ISSUE);
   assign bus_cmd   = bus_valid ? cmd_q : BC_NONE;
   assign bus_addr  = baddr_q;
   assign bus_wdata = bwd_q;

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int LINES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic [1:0]        cpu_op,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_valid,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              shared_in,
   output logic              shared_out,
   output logic              flush_valid,
   output logic [DATA_W-1:0] flush_data,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_chk_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("ADDR_W must exceed log2(LINES)");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0]  lk_idx;
   line_st_t          lk_st;
   logic [TAG_W-1:0]  lk_tag;
   logic [DATA_W-1:0] lk_data;
   line_st_t          sn_st;
   logic [TAG_W-1:0]  sn_tag;
   logic [DATA_W-1:0] sn_data;
   logic              a_we;
   line_st_t          a_wst;
   logic [TAG_W-1:0]  a_wtag;
   logic [DATA_W-1:0] a_wdata;
   logic              b_we;
   line_st_t          b_wst;

   mesi_line_store #(
      .LINES  (LINES),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_ridx  (lk_idx),
      .a_rst   (lk_st),
      .a_rtag  (lk_tag),
      .a_rdata (lk_data),
      .b_ridx  (snp_addr[IDX_W-1:0]),
      .b_rst   (sn_st),
      .b_rtag  (sn_tag),
      .b_rdata (sn_data),
      .a_we    (a_we),
      .a_widx  (lk_idx),
      .a_wst   (a_wst),
      .a_wtag  (a_wtag),
      .a_wdata (a_wdata),
      .b_we    (b_we),
      .b_widx  (snp_addr[IDX_W-1:0]),
      .b_wst   (b_wst)
   );

   mesi_snoop_resp #(
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) u_snoop (
      .clk         (clk),
      .rst_n       (rst_n),
      .snp_valid   (snp_valid),
      .snp_cmd     (snp_cmd),
      .snp_tag     (snp_addr[ADDR_W-1:IDX_W]),
      .ln_st       (sn_st),
      .ln_tag      (sn_tag),
      .ln_data     (sn_data),
      .upd_en      (b_we),
      .upd_st      (b_wst),
      .shared_out  (shared_out),
      .flush_valid (flush_valid),
      .flush_data  (flush_data)
   );

   mesi_req_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_valid (cpu_valid),
      .cpu_op    (cpu_op),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .snp_valid (snp_valid),
      .shared_in (shared_in),
      .mem_rdata (mem_rdata),
      .lk_idx    (lk_idx),
      .lk_st     (lk_st),
      .lk_tag    (lk_tag),
      .lk_data   (lk_data),
      .cpu_ready (cpu_ready),
      .cpu_done  (cpu_done),
      .cpu_rdata (cpu_rdata),
      .bus_valid (bus_valid),
      .bus_cmd   (bus_cmd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .wr_en     (a_we),
      .wr_st     (a_wst),
      .wr_tag    (a_wtag),
      .wr_data   (a_wdata)
   );

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_valid,
   input logic       cpu_ready,
   input logic       cpu_done,
   input logic       bus_valid,
   input logic [2:0] bus_cmd,
   input logic       snp_valid,
   input logic [2:0] snp_cmd,
   input logic       shared_out,
   input logic       flush_valid
);

   assert_shared_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      shared_out |-> $past(snp_valid && snp_cmd == 3'd1));

   assert_flush_after_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> $past(snp_valid && snp_cmd >= 3'd1 && snp_cmd <= 3'd3));

   assert_read_completes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd == 3'd1) |-> ##2 cpu_done);

   assert_own_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && (bus_cmd == 3'd2 || bus_cmd == 3'd3)) |-> ##2 cpu_done);

   assert_wb_followed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd == 3'd4) |-> ##2 (cpu_done || bus_valid));

   assert_cmd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> !bus_valid);

   assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid || snp_valid) |-> !(cpu_valid && cpu_ready));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_valid   (cpu_valid),
   .cpu_ready   (cpu_ready),
   .cpu_done    (cpu_done),
   .bus_valid   (bus_valid),
   .bus_cmd     (bus_cmd),
   .snp_valid   (snp_valid),
   .snp_cmd     (snp_cmd),
   .shared_out  (shared_out),
   .flush_valid (flush_valid)
);

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_valid = 1'b0;
   logic [1:0]    cpu_op = '0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready, cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic          bus_valid;
   logic [2:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          snp_valid = 1'b0;
   logic [2:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          shared_in = 1'b0;
   logic          shared_out, flush_valid;
   logic [DW-1:0] flush_data;
   logic [DW-1:0] mem_rdata = '0;

   int n_chk = 0;
   int n_err = 0;

   // line model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
   int          m_st  [NL];
   logic [3:0]  m_tag [NL];
   logic [DW-1:0] m_dat [NL];

   always #2.5 clk = ~clk;

   mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_valid(bus_valid),
      .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .shared_in(shared_in), .shared_out(shared_out), .flush_valid(flush_valid),
      .flush_data(flush_data), .mem_rdata(mem_rdata));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_cpu(input int op, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wd, input bit sh,
                          input logic [DW-1:0] mem);
      int ix = int'(addr[1:0]);
      logic [3:0] tg = addr[5:2];
      bit hit = (m_st[ix] != 0) && (m_tag[ix] == tg);
      bit vic = (m_st[ix] == 3) && !hit;
      int en = 0;
      logic [2:0] c0 = 0, c1 = 0;
      logic [AW-1:0] a0 = 0, a1 = 0;
      logic [DW-1:0] w0 = 0, erd = 0;
      int edone = 1;
      bit chk_rd = 1;
      string rq;
      int gn = 0, gdone = 0;
      logic [2:0] gc0 = 0, gc1 = 0;
      logic [AW-1:0] ga0 = 0, ga1 = 0;
      logic [DW-1:0] gw0 = 0, grd = 0;
      bit rdy_bad = 0, side_bad = 0;

      if (op == 0) begin
         if (hit) begin
            rq = "R2"; erd = m_dat[ix];
         end else begin
            if (vic) begin
               rq = "R9"; en = 2; c0 = 3'd4; a0 = {m_tag[ix], addr[1:0]};
               w0 = m_dat[ix]; c1 = 3'd1; a1 = addr; edone = 5;
            end else begin
               rq = "R3"; en = 1; c0 = 3'd1; a0 = addr; edone = 3;
            end
            m_st[ix] = sh ? 1 : 2; m_tag[ix] = tg; m_dat[ix] = mem; erd = mem;
         end
      end else if (op == 1) begin
         rq = "R4"; erd = wd;
         if (hit && m_st[ix] == 1) begin
            en = 1; c0 = 3'd3; a0 = addr; edone = 3;
         end else if (!hit) begin
            if (vic) begin
               rq = "R9"; en = 2; c0 = 3'd4; a0 = {m_tag[ix], addr[1:0]};
               w0 = m_dat[ix]; c1 = 3'd2; a1 = addr; edone = 5;
            end else begin
               en = 1; c0 = 3'd2; a0 = addr; edone = 3;
            end
         end
         m_st[ix] = 3; m_tag[ix] = tg; m_dat[ix] = wd;
      end else begin
         rq = "R8"; chk_rd = 0;
         if (hit && m_st[ix] == 3) begin
            en = 1; c0 = 3'd4; a0 = addr; w0 = m_dat[ix]; edone = 3;
         end
         if (hit) m_st[ix] = 0;
      end

      @(negedge clk);
      cpu_valid = 1'b1; cpu_op = 2'(op); cpu_addr = addr; cpu_wdata = wd;
      shared_in = sh; mem_rdata = mem;
      chk("R10", "ready when idle", 32'(cpu_ready), 32'd1);
      @(posedge clk);
      @(negedge clk);
      cpu_valid = 1'b0;
      for (int cyc = 1; cyc <= 8 && gdone == 0; cyc++) begin
         if (cyc > 1) @(negedge clk);
         if (shared_out || flush_valid) side_bad = 1;
         if (bus_valid) begin
            if (gn == 0) begin gc0 = bus_cmd; ga0 = bus_addr; gw0 = bus_wdata; end
            else begin gc1 = bus_cmd; ga1 = bus_addr; end
            gn++;
         end
         if (cpu_done) begin
            gdone = cyc; grd = cpu_rdata;
         end else if (cpu_ready) rdy_bad = 1;
      end
      chk(rq, "bus command count", 32'(gn), 32'(en));
      if (en > 0) begin
         chk(rq, "first command", 32'(gc0), 32'(c0));
         chk(rq, "first address", 32'(ga0), 32'(a0));
         if (c0 == 3'd4) chk(rq, "write-back data", 32'(gw0), 32'(w0));
      end
      if (en > 1) begin
         chk("R9", "fill command", 32'(gc1), 32'(c1));
         chk("R9", "fill address", 32'(ga1), 32'(a1));
      end
      chk(rq, "done cycle", 32'(gdone), 32'(edone));
      if (chk_rd) chk(rq, "returned word", 32'(grd), 32'(erd));
      chk("R10", "ready low while busy", 32'(rdy_bad), 32'd0);
      chk("R7", "no snoop response without snoop", 32'(side_bad), 32'd0);
   endtask

   task automatic run_snoop(input int cmd, input logic [AW-1:0] addr);
      int ix = int'(addr[1:0]);
      bit hit = (m_st[ix] != 0) && (m_tag[ix] == addr[5:2]);
      bit esh = (cmd == 1) && hit;
      bit efl = hit && (m_st[ix] == 3) && (cmd >= 1 && cmd <= 3);
      logic [DW-1:0] efd = m_dat[ix];
      string rq = "R7";
      if (hit && cmd == 1) begin rq = "R5"; m_st[ix] = 1; end
      else if (hit && (cmd == 2 || cmd == 3)) begin rq = "R6"; m_st[ix] = 0; end
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = 3'(cmd); snp_addr = addr;
      #1;
      chk("R10", "ready low during snoop", 32'(cpu_ready), 32'd0);
      @(posedge clk);
      @(negedge clk);
      snp_valid = 1'b0;
      chk(rq, "shared_out", 32'(shared_out), 32'(esh));
      chk(rq, "flush_valid", 32'(flush_valid), 32'(efl));
      if (efl) chk(rq, "flush_data", 32'(flush_data), 32'(efd));
   endtask

   task automatic clear_line(input int ix);
      if (m_st[ix] != 0) run_cpu(2, {m_tag[ix], 2'(ix)}, '0, 1'b0, '0);
   endtask

   task automatic setup_line(input logic [AW-1:0] a, input int init, input int seed);
      clear_line(int'(a[1:0]));
      if (init == 1) run_cpu(0, a, '0, 1'b1, 16'h5100 + 16'(seed));
      if (init >= 2) run_cpu(0, a, '0, 1'b0, 16'h5200 + 16'(seed));
      if (init == 3) run_cpu(1, a, 16'h6300 + 16'(seed), 1'b0, '0);
   endtask

   initial begin
      int wd_cnt = 0;
      while (wd_cnt < 150000) begin
         @(posedge clk);
         wd_cnt++;
      end
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=0", wd_cnt);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset ready", 32'(cpu_ready), 32'd1);
      chk("R1", "reset bus_valid", 32'(bus_valid), 32'd0);
      chk("R1", "reset cpu_done", 32'(cpu_done), 32'd0);
      chk("R1", "reset shared_out", 32'(shared_out), 32'd0);
      chk("R1", "reset flush_valid", 32'(flush_valid), 32'd0);
      // R1: every line Invalid, so a snoop read finds nothing and a read misses
      for (int i = 0; i < NL; i++) run_snoop(1, 6'(i));
      run_cpu(0, 6'h05, '0, 1'b0, 16'h1111);

      // directed sweep: each starting state against each event
      for (int init = 0; init < 4; init++) begin
         for (int ev = 0; ev < 9; ev++) begin
            logic [1:0] ix = 2'((init * 9 + ev) % NL);
            logic [AW-1:0] a = {4'd1, ix};
            logic [AW-1:0] b = {4'd2, ix};
            int sd = init * 16 + ev;
            setup_line(a, init, sd);
            case (ev)
               0: run_cpu(0, a, '0, 1'(ev & 1), 16'h7000 + 16'(sd));
               1: run_cpu(1, a, 16'h8000 + 16'(sd), 1'b0, '0);
               2: run_cpu(2, a, '0, 1'b0, '0);
               3: run_snoop(1, a);
               4: run_snoop(2, a);
               5: run_snoop(3, a);
               6: run_snoop(4, a);
               7: run_cpu(0, b, '0, 1'b1, 16'h9000 + 16'(sd));
               default: run_cpu(1, b, 16'hA000 + 16'(sd), 1'b0, '0);
            endcase
            // observe resulting state through a snoop read
            run_snoop(1, a);
         end
      end

      // pseudo-random mixed sweep
      for (int step = 0; step < 500; step++) begin
         logic [AW-1:0] a;
         int kind;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = {4'(lfsr[3:2] % 3), lfsr[1:0]};
         kind = int'(lfsr[7:4]) % 6;
         if (kind < 4)
            run_cpu(kind % 3, a, lfsr ^ 16'h3C3C, lfsr[8], {lfsr[7:0], 8'(step)});
         else
            run_snoop(int'(lfsr[10:9]) + 1 + int'(lfsr[11] & lfsr[12] & lfsr[10] & lfsr[9]), a);
      end

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule